// File: doc/BRIEF.md
# Byte-Serial 8086 MOV Decoder

This block takes 8086 machine code one byte at a time and picks out the MOV encodings. It covers the accumulator-from-absolute-address load, the register-immediate short form, the ModRM forms with a register on one side, the segment-register store and the two memory-or-register immediate forms. For every instruction it gives one result record. The record holds the encoding form, the kind and register number of the destination and the source, the memory addressing combination, the operand size, the assembled displacement and immediate, and the total byte count.

Bytes enter on a valid/ready pair. The record comes out on a second valid/ready pair. A record is raised on the cycle after the final byte of an instruction is taken. It stays on the outputs until the consumer accepts it, and no input byte is taken during that time. An opcode outside the supported set gives an invalid record. So does an immediate form whose ModRM reg field is not zero. In both cases the next byte is treated as a new opcode.

Top module: `mov_decoder`

## Requirements
- R1: Opcodes B8h to BFh give form_o=1, dst_kind_o=1 (register) with dst_reg_o equal to opcode bits [2:0], src_kind_o=5 (immediate), word_o=1 and length_o=3.
- R2: Opcode C7h with ModRM reg=0 gives form_o=2, word_o=1 and a 16-bit immediate that follows any displacement. C7 04 00 00 gives dst_kind_o=3 (memory) with mem_rm_o=4, imm_o=0 and length_o=4.
- R3: Opcode C6h with ModRM reg=0 gives form_o=3, word_o=0 and a one-byte immediate in imm_o[7:0] with imm_o[15:8]=0. A register destination (mod=3) gives dst_kind_o=1 with the r/m number.
- R4: 8Bh gives form_o=4 (dst register=reg, src=r/m). 89h gives form_o=5 (dst=r/m, src register=reg). 8Ch gives form_o=6 (dst=r/m, src_kind_o=2 segment register with number=reg).
- R5: A1h gives form_o=7, dst_kind_o=1 with register 0, src_kind_o=4 (direct address), and the two bytes that follow the opcode as disp_o. There is no ModRM byte and length_o=3.
- R6: For the r/m operand, ModRM mode (bits 7:6) 0 means memory with no displacement. Mode 0 with r/m=6 means a direct 16-bit address (kind 4). Mode 1 adds an 8-bit displacement sign-extended to 16 bits. Mode 2 adds a 16-bit displacement. Mode 3 means register r/m. For memory, mem_rm_o carries the r/m bits.
- R7: Multi-byte displacements, addresses and immediates are assembled with the low byte first.
- R8: Any opcode that is not listed gives form_o=0, invalid_o=1, both kinds 0 (none) and length_o=1. The following byte is decoded as an opcode.
- R9: C6h or C7h with a nonzero ModRM reg field gives form_o=0, invalid_o=1 and length_o=2. The following byte is decoded as an opcode.
- R10: res_valid_o rises only on the cycle after the final byte of an instruction is taken. The record then holds steady until res_ready_i. byte_ready_o is low exactly while a record is pending, and no byte is lost or taken twice.
- R11: Reset clears any pending record and any partly received instruction. After reset, byte_ready_o=1 and res_valid_o=0.
- R12: length_o counts every byte of the instruction, from 1 up to 6 (opcode, ModRM, 16-bit displacement and 16-bit immediate).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_i | input | 8 | Code byte |
| byte_valid_i | input | 1 | Code byte present |
| byte_ready_o | output | 1 | Decoder can take a byte |
| res_valid_o | output | 1 | Result record present |
| res_ready_i | input | 1 | Consumer takes the record |
| form_o | output | 3 | Encoding form code (0 invalid, 1..7 per R1-style codes) |
| invalid_o | output | 1 | Unsupported or malformed encoding |
| dst_kind_o | output | 3 | Destination kind: 0 none, 1 reg, 2 segment reg, 3 memory, 4 direct, 5 immediate |
| dst_reg_o | output | 3 | Destination register number |
| src_kind_o | output | 3 | Source kind, same coding |
| src_reg_o | output | 3 | Source register number |
| mem_rm_o | output | 3 | Addressing combination of a memory operand |
| word_o | output | 1 | 16-bit operand size |
| disp_o | output | 16 | Displacement or direct address |
| imm_o | output | 16 | Immediate value |
| length_o | output | 3 | Instruction length in bytes |

## Verification
The bench builds the decoder with its default package constants, which are 8-bit code bytes, 16-bit words and a six-byte maximum length. With these values the whole legal length range is reachable, from the one-byte invalid opcode up to the six-byte immediate store that has a 16-bit displacement. Sign extension of a negative 8-bit displacement can be observed. The direct-address exception in the mode-0 r/m decode can be observed. Resynchronisation after both kinds of invalid encoding is covered, as are a byte held on the input while a record is pending and a reset that arrives partway through an instruction.

// File: rtl/mov_dec_pkg.sv
package mov_dec_pkg;
  localparam int BYTE_W  = 8;
  localparam int WORD_W  = 2 * BYTE_W;
  localparam int MAX_LEN = 6;
  localparam int LEN_W   = $clog2(MAX_LEN + 1);
  localparam int REG_W   = 3;

  typedef enum logic [2:0] {
    FORM_INVALID      = 3'd0,
    FORM_R16_IMM      = 3'd1,
    FORM_RM16_IMM     = 3'd2,
    FORM_RM8_IMM      = 3'd3,
    FORM_R16_FROM_RM  = 3'd4,
    FORM_RM_FROM_R16  = 3'd5,
    FORM_RM_FROM_SREG = 3'd6,
    FORM_AX_FROM_ABS  = 3'd7
  } form_e;

  typedef enum logic [2:0] {
    KIND_NONE   = 3'd0,
    KIND_REG    = 3'd1,
    KIND_SREG   = 3'd2,
    KIND_MEM    = 3'd3,
    KIND_DIRECT = 3'd4,
    KIND_IMM    = 3'd5
  } kind_e;

  typedef struct packed {
    logic [1:0]       mode;
    logic [REG_W-1:0] reg_f;
    logic [REG_W-1:0] rm;
  } modrm_t;

  typedef enum logic [1:0] {ST_OP, ST_MODRM, ST_DISP, ST_IMM} st_e;
endpackage

// File: rtl/mov_opcode_class.sv
module mov_opcode_class
  import mov_dec_pkg::*;
(
  input  logic [BYTE_W-1:0] op_i,
  output form_e             form_o,
  output logic              has_modrm_o,
  output logic [1:0]        imm_bytes_o,
  output logic [1:0]        addr_bytes_o
);
  always_comb begin
    form_o       = FORM_INVALID;
    has_modrm_o  = 1'b0;
    imm_bytes_o  = 2'd0;
    addr_bytes_o = 2'd0;
    if (op_i[7:3] == 5'b10111) begin
      form_o      = FORM_R16_IMM;
      imm_bytes_o = 2'd2;
    end else begin
      case (op_i)
        8'hC7: begin form_o = FORM_RM16_IMM;     has_modrm_o = 1'b1; imm_bytes_o = 2'd2; end
        8'hC6: begin form_o = FORM_RM8_IMM;      has_modrm_o = 1'b1; imm_bytes_o = 2'd1; end
        8'h8B: begin form_o = FORM_R16_FROM_RM;  has_modrm_o = 1'b1; end
        8'h89: begin form_o = FORM_RM_FROM_R16;  has_modrm_o = 1'b1; end
        8'h8C: begin form_o = FORM_RM_FROM_SREG; has_modrm_o = 1'b1; end
        8'hA1: begin form_o = FORM_AX_FROM_ABS;  addr_bytes_o = 2'd2; end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/mov_modrm_disp.sv
module mov_modrm_disp
  import mov_dec_pkg::*;
(
  input  logic [1:0]       mode_i,
  input  logic [REG_W-1:0] rm_i,
  output logic [1:0]       disp_bytes_o
);
  always_comb begin
    case (mode_i)
      2'b00:   disp_bytes_o = (rm_i == 3'b110) ? 2'd2 : 2'd0;
      2'b01:   disp_bytes_o = 2'd1;
      2'b10:   disp_bytes_o = 2'd2;
      default: disp_bytes_o = 2'd0;
    endcase
  end
endmodule

// File: rtl/mov_operand_map.sv
module mov_operand_map
  import mov_dec_pkg::*;
(
  input  form_e            form_i,
  input  logic [REG_W-1:0] op_lo_i,
  input  modrm_t           modrm_i,
  output kind_e            dst_kind_o,
  output logic [REG_W-1:0] dst_reg_o,
  output kind_e            src_kind_o,
  output logic [REG_W-1:0] src_reg_o,
  output logic [REG_W-1:0] mem_rm_o,
  output logic             word_o
);
  kind_e            rm_kind;
  logic [REG_W-1:0] rm_reg;
  logic [REG_W-1:0] rm_mem;
  logic             rm_used;

  always_comb begin
    rm_reg = '0;
    rm_mem = '0;
    if (modrm_i.mode == 2'b11) begin
      rm_kind = KIND_REG;
      rm_reg  = modrm_i.rm;
    end else if (modrm_i.mode == 2'b00 && modrm_i.rm == 3'b110) begin
      rm_kind = KIND_DIRECT;
    end else begin
      rm_kind = KIND_MEM;
      rm_mem  = modrm_i.rm;
    end
  end

  always_comb begin
    dst_kind_o = KIND_NONE;
    src_kind_o = KIND_NONE;
    dst_reg_o  = '0;
    src_reg_o  = '0;
    rm_used    = 1'b0;
    word_o     = 1'b1;
    case (form_i)
      FORM_R16_IMM: begin
        dst_kind_o = KIND_REG; dst_reg_o = op_lo_i; src_kind_o = KIND_IMM;
      end
      FORM_RM16_IMM, FORM_RM8_IMM: begin
        dst_kind_o = rm_kind; dst_reg_o = rm_reg; src_kind_o = KIND_IMM; rm_used = 1'b1;
        word_o     = (form_i == FORM_RM16_IMM);
      end
      FORM_R16_FROM_RM: begin
        dst_kind_o = KIND_REG; dst_reg_o = modrm_i.reg_f;
        src_kind_o = rm_kind;  src_reg_o = rm_reg; rm_used = 1'b1;
      end
      FORM_RM_FROM_R16: begin
        dst_kind_o = rm_kind;  dst_reg_o = rm_reg; rm_used = 1'b1;
        src_kind_o = KIND_REG; src_reg_o = modrm_i.reg_f;
      end
      FORM_RM_FROM_SREG: begin
        dst_kind_o = rm_kind;   dst_reg_o = rm_reg; rm_used = 1'b1;
        src_kind_o = KIND_SREG; src_reg_o = modrm_i.reg_f;
      end
      FORM_AX_FROM_ABS: begin
        dst_kind_o = KIND_REG; src_kind_o = KIND_DIRECT;
      end
      default: word_o = 1'b0;
    endcase
    mem_rm_o = rm_used ? rm_mem : '0;
  end
endmodule

// File: rtl/mov_decoder.sv
module mov_decoder
  import mov_dec_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        byte_i,
  input  logic              byte_valid_i,
  output logic              byte_ready_o,
  output logic              res_valid_o,
  input  logic              res_ready_i,
  output logic [2:0]        form_o,
  output logic              invalid_o,
  output logic [2:0]        dst_kind_o,
  output logic [2:0]        dst_reg_o,
  output logic [2:0]        src_kind_o,
  output logic [2:0]        src_reg_o,
  output logic [2:0]        mem_rm_o,
  output logic              word_o,
  output logic [15:0]       disp_o,
  output logic [15:0]       imm_o,
  output logic [2:0]        length_o
);
  st_e               state_q;
  form_e             form_q;
  logic [REG_W-1:0]  op_lo_q;
  modrm_t            modrm_q;
  logic [WORD_W-1:0] disp_q, imm_q;
  logic [LEN_W-1:0]  len_q;
  logic [1:0]        disp_left_q, imm_left_q;
  logic              hi_sel_q;
  logic              res_valid_q;

  form_e      cls_form;
  logic       cls_modrm;
  logic [1:0] cls_imm, cls_addr;
  logic [1:0] in_disp;
  logic       take;
  kind_e      dst_kind, src_kind;
  modrm_t     in_modrm;

  assign take     = byte_valid_i && !res_valid_q;
  assign in_modrm = modrm_t'(byte_i);

  mov_opcode_class u_class (
    .op_i(byte_i), .form_o(cls_form), .has_modrm_o(cls_modrm),
    .imm_bytes_o(cls_imm), .addr_bytes_o(cls_addr)
  );

  mov_modrm_disp u_disp (
    .mode_i(in_modrm.mode), .rm_i(in_modrm.rm), .disp_bytes_o(in_disp)
  );

  mov_operand_map u_map (
    .form_i(form_q), .op_lo_i(op_lo_q), .modrm_i(modrm_q),
    .dst_kind_o(dst_kind), .dst_reg_o(dst_reg_o),
    .src_kind_o(src_kind), .src_reg_o(src_reg_o),
    .mem_rm_o(mem_rm_o), .word_o(word_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_OP;
      form_q      <= FORM_INVALID;
      op_lo_q     <= '0;
      modrm_q     <= '0;
      disp_q      <= '0;
      imm_q       <= '0;
      len_q       <= '0;
      disp_left_q <= '0;
      imm_left_q  <= '0;
      hi_sel_q    <= 1'b0;
      res_valid_q <= 1'b0;
    end else begin
      if (res_valid_q && res_ready_i) res_valid_q <= 1'b0;
      if (take) begin
        len_q <= (state_q == ST_OP) ? LEN_W'(1) : len_q + LEN_W'(1);
        case (state_q)
          ST_OP: begin
            op_lo_q     <= byte_i[2:0];
            modrm_q     <= '0;
            disp_q      <= '0;
            imm_q       <= '0;
            form_q      <= cls_form;
            imm_left_q  <= cls_imm;
            disp_left_q <= cls_addr;
            hi_sel_q    <= 1'b0;
            if (cls_form == FORM_INVALID) res_valid_q <= 1'b1;
            else if (cls_modrm)           state_q <= ST_MODRM;
            else if (cls_addr != 2'd0)    state_q <= ST_DISP;
            else                          state_q <= ST_IMM;
          end
          ST_MODRM: begin
            modrm_q <= in_modrm;
            // immediate forms only exist with reg field 0
            if ((form_q == FORM_RM16_IMM || form_q == FORM_RM8_IMM) && in_modrm.reg_f != '0) begin
              form_q      <= FORM_INVALID;
              res_valid_q <= 1'b1;
              state_q     <= ST_OP;
            end else begin
              disp_left_q <= in_disp;
              if (in_disp != 2'd0)         state_q <= ST_DISP;
              else if (imm_left_q != 2'd0) state_q <= ST_IMM;
              else begin
                res_valid_q <= 1'b1;
                state_q     <= ST_OP;
              end
            end
          end
          ST_DISP: begin
            if (!hi_sel_q) disp_q <= {{BYTE_W{byte_i[7]}}, byte_i};
            else           disp_q[WORD_W-1:BYTE_W] <= byte_i;
            hi_sel_q    <= !hi_sel_q;
            disp_left_q <= disp_left_q - 2'd1;
            if (disp_left_q == 2'd1) begin
              hi_sel_q <= 1'b0;
              if (imm_left_q != 2'd0) state_q <= ST_IMM;
              else begin
                res_valid_q <= 1'b1;
                state_q     <= ST_OP;
              end
            end
          end
          default: begin
            if (!hi_sel_q) imm_q <= {{BYTE_W{1'b0}}, byte_i};
            else           imm_q[WORD_W-1:BYTE_W] <= byte_i;
            hi_sel_q   <= !hi_sel_q;
            imm_left_q <= imm_left_q - 2'd1;
            if (imm_left_q == 2'd1) begin
              res_valid_q <= 1'b1;
              state_q     <= ST_OP;
            end
          end
        endcase
      end
    end
  end

  assign byte_ready_o = !res_valid_q;
  assign res_valid_o  = res_valid_q;
  assign form_o       = form_q;
  assign invalid_o    = (form_q == FORM_INVALID);
  assign dst_kind_o   = dst_kind;
  assign src_kind_o   = src_kind;
  assign disp_o       = disp_q;
  assign imm_o        = imm_q;
  assign length_o     = len_q;

  a_r10_rise_after_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(res_valid_o) |-> $past(byte_valid_i && byte_ready_o));
  a_r10_hold_until_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o && !res_ready_i |=> res_valid_o && $stable(length_o) && $stable(form_o)
      && $stable(disp_o) && $stable(imm_o));
  a_r12_length_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> (length_o >= 3'd1 && length_o <= 3'd6));
  a_r8_invalid_short: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o && invalid_o |-> length_o <= 3'd2 && dst_kind_o == 3'd0 && src_kind_o == 3'd0);
  a_r3_imm8_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o && form_o == 3'd3 |-> imm_o[15:8] == 8'h00 && !word_o);
  a_r1_short_form_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o && form_o == 3'd1 |-> length_o == 3'd3);
endmodule

// File: tb/mov_decoder_test.sv
`timescale 1ns/1ps
module mov_decoder_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] byte_i = '0;
  logic byte_valid = 1'b0, res_ready = 1'b0;
  logic byte_ready, res_valid, invalid, word;
  logic [2:0] form, dk, dr, sk, sr, rm, len;
  logic [15:0] disp, imm;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  mov_decoder uut (
    .clk_i(clk), .rst_ni(rst_n), .byte_i(byte_i), .byte_valid_i(byte_valid),
    .byte_ready_o(byte_ready), .res_valid_o(res_valid), .res_ready_i(res_ready),
    .form_o(form), .invalid_o(invalid), .dst_kind_o(dk), .dst_reg_o(dr),
    .src_kind_o(sk), .src_reg_o(sr), .mem_rm_o(rm), .word_o(word),
    .disp_o(disp), .imm_o(imm), .length_o(len)
  );

  typedef struct packed {
    logic [47:0] b; logic [2:0] n;
    logic [2:0] form, dk, dr, sk, sr, rm; logic w;
    logic [15:0] disp, imm; logic [2:0] len; logic inv; logic [3:0] req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{48'h0000_0012_34B8, 3'd3, 3'd1, 3'd1, 3'd0, 3'd5, 3'd0, 3'd0, 1'b1, 16'h0000, 16'h1234, 3'd3, 1'b0, 4'd1},  // R1 ax
    '{48'h0000_00AB_CDBF, 3'd3, 3'd1, 3'd1, 3'd7, 3'd5, 3'd0, 3'd0, 1'b1, 16'h0000, 16'hABCD, 3'd3, 1'b0, 4'd1},  // R1 di
    '{48'h0000_0000_04C7, 3'd4, 3'd2, 3'd3, 3'd0, 3'd5, 3'd0, 3'd4, 1'b1, 16'h0000, 16'h0000, 3'd4, 1'b0, 4'd2},  // R2 [si],0
    '{48'h0000_5AF0_47C6, 3'd4, 3'd3, 3'd3, 3'd0, 3'd5, 3'd0, 3'd7, 1'b0, 16'hFFF0, 16'h005A, 3'd4, 1'b0, 4'd6},  // R6 disp8 negative
    '{48'h5678_1234_06C7, 3'd6, 3'd2, 3'd4, 3'd0, 3'd5, 3'd0, 3'd0, 1'b1, 16'h1234, 16'h5678, 3'd6, 1'b0, 4'd12}, // R12 direct, len 6
    '{48'hBEEF_8000_84C7, 3'd6, 3'd2, 3'd3, 3'd0, 3'd5, 3'd0, 3'd4, 1'b1, 16'h8000, 16'hBEEF, 3'd6, 1'b0, 4'd7},  // R7 disp16+imm16
    '{48'h0000_0002_5C8B, 3'd3, 3'd4, 3'd1, 3'd3, 3'd3, 3'd0, 3'd4, 1'b1, 16'h0002, 16'h0000, 3'd3, 1'b0, 4'd4},  // R4 load
    '{48'h0000_0000_D889, 3'd2, 3'd5, 3'd1, 3'd0, 3'd1, 3'd3, 3'd0, 1'b1, 16'h0000, 16'h0000, 3'd2, 1'b0, 4'd4},  // R4 store reg
    '{48'h0000_0000_D88C, 3'd2, 3'd6, 3'd1, 3'd0, 3'd2, 3'd3, 3'd0, 1'b1, 16'h0000, 16'h0000, 3'd2, 1'b0, 4'd4},  // R4 sreg
    '{48'h0000_0012_34A1, 3'd3, 3'd7, 3'd1, 3'd0, 3'd4, 3'd0, 3'd0, 1'b1, 16'h1234, 16'h0000, 3'd3, 1'b0, 4'd5},  // R5
    '{48'h0000_0000_0090, 3'd1, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 1'b0, 16'h0000, 16'h0000, 3'd1, 1'b1, 4'd8},  // R8
    '{48'h0000_0000_08C7, 3'd2, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 1'b0, 16'h0000, 16'h0000, 3'd2, 1'b1, 4'd9},  // R9
    '{48'h0000_007F_C1C6, 3'd3, 3'd3, 3'd1, 3'd1, 3'd5, 3'd0, 3'd0, 1'b0, 16'h0000, 16'h007F, 3'd3, 1'b0, 4'd3},  // R3 reg dst, after R9 resync
    '{48'h0000_0000_078B, 3'd2, 3'd4, 3'd1, 3'd0, 3'd3, 3'd0, 3'd7, 1'b1, 16'h0000, 16'h0000, 3'd2, 1'b0, 4'd6}   // R6 mode 0
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] pack_out();
    return {form, dk, dr, sk, sr, rm, word, disp, imm, len, invalid};
  endfunction

  task automatic accept(input string req);
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    chk(!res_valid && byte_ready, req, "accept clears", {62'd0, res_valid, byte_ready}, 64'd1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!res_valid && byte_ready, "R11", "reset state", {62'd0, res_valid, byte_ready}, 64'd1);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      for (int i = 0; i < int'(VECS[v].n); i++) begin
        @(negedge clk);
        if (i == int'(VECS[v].n) - 1)
          chk(!res_valid, "R10", "no result before last byte", {63'd0, res_valid}, 64'd0);
        byte_i = VECS[v].b[i*8 +: 8];
        byte_valid = 1'b1;
      end
      @(negedge clk);
      byte_valid = 1'b0;
      chk(res_valid, "R10", "result after last byte", {63'd0, res_valid}, 64'd1);
      begin
        logic [63:0] exp;
        exp = {VECS[v].form, VECS[v].dk, VECS[v].dr, VECS[v].sk, VECS[v].sr, VECS[v].rm,
               VECS[v].w, VECS[v].disp, VECS[v].imm, VECS[v].len, VECS[v].inv};
        chk(pack_out() == exp, $sformatf("R%0d", VECS[v].req), $sformatf("vector %0d", v),
            pack_out(), exp);
      end
      @(negedge clk);
      chk(res_valid && !byte_ready, "R10", "held while pending", {62'd0, res_valid, byte_ready}, 64'd2);
      accept("R10");
    end

    // R10: byte offered while a record is pending is taken exactly once afterwards
    byte_i = 8'hA1; byte_valid = 1'b1;
    @(negedge clk); byte_i = 8'h34;
    @(negedge clk); byte_i = 8'h12;
    @(negedge clk); byte_i = 8'hB8;
    repeat (3) @(negedge clk);
    chk(res_valid && disp == 16'h1234 && form == 3'd7, "R10", "stall holds record",
        {45'd0, res_valid, form, disp}, {45'd0, 1'b1, 3'd7, 16'h1234});
    res_ready = 1'b1;
    @(negedge clk); res_ready = 1'b0;
    @(negedge clk); byte_i = 8'h34;
    @(negedge clk); byte_i = 8'h12;
    @(negedge clk); byte_valid = 1'b0;
    chk(res_valid && form == 3'd1 && imm == 16'h1234 && len == 3'd3, "R10", "stalled byte used once",
        {41'd0, res_valid, form, imm, len}, {41'd0, 1'b1, 3'd1, 16'h1234, 3'd3});
    accept("R10");

    // R11: reset in the middle of an instruction drops it
    byte_i = 8'hC7; byte_valid = 1'b1;
    @(negedge clk); byte_valid = 1'b0; rst_n = 1'b0;
    @(negedge clk);
    chk(!res_valid && byte_ready, "R11", "reset mid instruction", {62'd0, res_valid, byte_ready}, 64'd1);
    rst_n = 1'b1;
    @(negedge clk); byte_i = 8'h90; byte_valid = 1'b1;
    @(negedge clk); byte_valid = 1'b0;
    chk(res_valid && invalid && len == 3'd1, "R11", "fresh opcode after reset",
        {59'd0, res_valid, invalid, len}, {59'd0, 1'b1, 1'b1, 3'd1});
    accept("R8");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule